// File: doc/BRIEF.md
# External Memory Wait-State Controller

The controller sits between an internal bus master and three external memory regions: static RAM, ROM and an extended-memory window. A master presents an address, a direction and write data with a request line and holds them until the controller answers with a one-cycle ready. The controller decodes which region the address falls in and drives that region's active-low chip select. It also drives active-low read or write strobes and stretches the access by a programmable number of wait cycles. A 16-bit access to a region configured for an 8-bit bus is split into two byte transfers.

One 16-bit control register, written and read through a simple register port, holds the settings for each region: a 3-bit wait count and an 8/16-bit width bit. It also holds two merge bits. A merge bit makes the RAM or ROM chip select follow the extended-memory select. Wait cycles are counted in cycles of the controller clock, which is nominally 48 MHz.

The sequencer has three states. IDLE waits for a request; on a request it captures the region, its wait count and width, and moves to BYTE_LO. BYTE_LO carries the first (or only) transfer. When its count expires it either finishes and returns to IDLE, or moves on to BYTE_HI for a split access. BYTE_HI carries the upper byte and returns to IDLE when its count expires.

Top module: `xmem_waitctl`

## Requirements
- R1: After reset the control register reads 0x0000, all three chip selects and both strobes are high, and ready is low.
- R2: Control register layout: RAM wait [2:0], RAM 8-bit [3], ROM wait [6:4], ROM 8-bit [7], extended wait [10:8], extended 8-bit [11], ROM merge [12], RAM merge [13]. A width bit of 1 selects 8 bits. Bits 15 and 14 always read back 0, and all other bits read back as written.
- R3: With default parameters, addresses 0x0000–0x3FFF select ROM, 0x4000–0x7FFF RAM and 0x8000–0xBFFF extended memory. An address of 0xC000 or above asserts no select and no strobe, finishes with ready one cycle after the request is taken, and returns read data 0.
- R4: The strobe phase of each transfer lasts W+1 cycles, where W is the region's wait count. Ready is high only in the final cycle of the access, so with W=0 a 16-bit-width access completes in one strobe cycle.
- R5: On an 8-bit region, an access takes two transfers of W+1 cycles each. The first has ext_addr bit 0 = 0 (low byte) and the second has bit 0 = 1 (high byte). On a 16-bit region ext_addr bit 0 is 0 throughout.
- R6: Read data: on a 16-bit region rd_data equals ext_din. On an 8-bit region rd_data is {ext_din[7:0] of the high transfer, ext_din[7:0] of the low transfer}.
- R7: Write data: on a 16-bit region ext_dout equals the write data. On an 8-bit region ext_dout[7:0] carries write-data bits [7:0] during the low transfer and bits [15:8] during the high transfer.
- R8: When bit 13 is 1, the RAM select is low in every cycle that the extended-memory select is low.
- R9: When bit 12 is 1, the ROM select is low in every cycle that the extended-memory select is low.
- R10: Exactly one native select is active during a mapped access, and a merge never asserts a select during a RAM or ROM access. The read strobe (reads) or write strobe (writes) stays low from the first strobe cycle until ready, and ready lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the wait-state time base |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read data |
| req | input | 1 | Access request, held until ready |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Word address of the access |
| req_wdata | input | 16 | Write data |
| rdy | output | 1 | Access completes in this cycle |
| rd_data | output | 16 | Read data, valid while rdy is high |
| ext_addr | output | AW+1 | External byte address: {req_addr, byte select} |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_oe_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 1 | Active-low write strobe |
| ram_cs_n | output | 1 | Active-low RAM select |
| rom_cs_n | output | 1 | Active-low ROM select |
| xm_cs_n | output | 1 | Active-low extended-memory select |

## Verification
The bench sweeps every wait count on every region in both widths, for reads and writes. It counts strobe cycles against W+1 or 2(W+1), so an off-by-one in the wait counter, or a split access that skips a transfer, shows up as a wrong cycle count. A wrong byte order or a lost low byte would give a swapped or stale read word and the wrong ext_addr bit 0 sequence. A width bit taken from the wrong region would give the wrong cycle count. The bench also probes the decode window edges on both sides and every merge-bit combination. A merge that leaked onto RAM or ROM accesses, or a select mapped to the wrong bit, would show an extra or missing select.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    localparam int WAIT_W = 3;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_RAM  = 2'd1,
        RG_ROM  = 2'd2,
        RG_XM   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BYTE_LO = 2'd1,
        ST_BYTE_HI = 2'd2
    } seq_state_e;

    // bit positions of the control register
    localparam int RAM_FLD  = 0;
    localparam int ROM_FLD  = 4;
    localparam int XM_FLD   = 8;
    localparam int WIDTH_OFS = 3;
    localparam int ROM_MRG  = 12;
    localparam int RAM_MRG  = 13;
endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] q
);
    logic [13:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q <= wdata[13:0];
        end
    end

    // reserved upper bits are never stored
    assign q = {2'b00, bits_q};
endmodule

// File: rtl/xmem_decode.sv
module xmem_decode
    import xmem_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] ROM_LO = 16'h0000,
    parameter logic [AW-1:0] ROM_HI = 16'h3FFF,
    parameter logic [AW-1:0] RAM_LO = 16'h4000,
    parameter logic [AW-1:0] RAM_HI = 16'h7FFF,
    parameter logic [AW-1:0] XM_LO  = 16'h8000,
    parameter logic [AW-1:0] XM_HI  = 16'hBFFF
) (
    input  logic [AW-1:0]     addr,
    input  logic [11:0]       cfg_fields,
    output region_e           region,
    output logic [WAIT_W-1:0] wait_cnt,
    output logic              narrow
);
    logic [3:0] fld;

    always_comb begin
        if (addr >= RAM_LO && addr <= RAM_HI) begin
            region = RG_RAM;
        end else if (addr >= ROM_LO && addr <= ROM_HI) begin
            region = RG_ROM;
        end else if (addr >= XM_LO && addr <= XM_HI) begin
            region = RG_XM;
        end else begin
            region = RG_NONE;
        end
    end

    always_comb begin
        unique case (region)
            RG_RAM:  fld = cfg_fields[RAM_FLD +: 4];
            RG_ROM:  fld = cfg_fields[ROM_FLD +: 4];
            RG_XM:   fld = cfg_fields[XM_FLD  +: 4];
            default: fld = 4'h0;
        endcase
    end

    assign wait_cnt = fld[WAIT_W-1:0];
    assign narrow   = fld[WIDTH_OFS];
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [AW-1:0]     req_addr,
    input  logic [15:0]       req_wdata,
    input  region_e           dec_region,
    input  logic [WAIT_W-1:0] dec_wait,
    input  logic              dec_narrow,
    input  logic              mrg_ram,
    input  logic              mrg_rom,
    input  logic [15:0]       ext_din,
    output logic              rdy,
    output logic [15:0]       rd_data,
    output logic [AW:0]       ext_addr,
    output logic [15:0]       ext_dout,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic              ram_cs_n,
    output logic              rom_cs_n,
    output logic              xm_cs_n
);
    seq_state_e        state, nxt;
    region_e           rg_q;
    logic [WAIT_W-1:0] wait_q, cnt;
    logic              narrow_q, wr_q;
    logic [7:0]        lo_q;
    logic              last_beat, active, mapped, hi_ph;

    assign last_beat = (cnt == wait_q);
    assign active    = (state != ST_IDLE);
    assign mapped    = (rg_q != RG_NONE);
    assign hi_ph     = (state == ST_BYTE_HI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: IDLE->BYTE_LO on req; BYTE_LO->BYTE_HI on split; ->IDLE at last beat
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req) nxt = ST_BYTE_LO;
            ST_BYTE_LO: if (last_beat) nxt = (narrow_q && mapped) ? ST_BYTE_HI : ST_IDLE;
            ST_BYTE_HI: if (last_beat) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // capture of access attributes, wait counter and low byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= RG_NONE;
            wait_q   <= '0;
            narrow_q <= 1'b0;
            wr_q     <= 1'b0;
            cnt      <= '0;
            lo_q     <= '0;
        end else begin
            if (state == ST_IDLE) begin
                cnt <= '0;
                if (req) begin
                    rg_q     <= dec_region;
                    wait_q   <= dec_wait;
                    narrow_q <= dec_narrow;
                    wr_q     <= req_wr;
                end
            end else if (last_beat) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (state == ST_BYTE_LO && last_beat) begin
                lo_q <= ext_din[7:0];
            end
        end
    end

    // outputs
    always_comb begin
        logic nat_ram, nat_rom, nat_xm;
        nat_ram  = active && (rg_q == RG_RAM);
        nat_rom  = active && (rg_q == RG_ROM);
        nat_xm   = active && (rg_q == RG_XM);
        ram_cs_n = !(nat_ram || (mrg_ram && nat_xm));
        rom_cs_n = !(nat_rom || (mrg_rom && nat_xm));
        xm_cs_n  = !nat_xm;
        ext_oe_n = !(active && mapped && !wr_q);
        ext_we_n = !(active && mapped && wr_q);
        rdy      = active && last_beat && (hi_ph || !narrow_q || !mapped);
        ext_addr = {req_addr, hi_ph};
        if (narrow_q) begin
            ext_dout = {8'h00, hi_ph ? req_wdata[15:8] : req_wdata[7:0]};
        end else begin
            ext_dout = req_wdata;
        end
        if (!mapped) begin
            rd_data = 16'h0000;
        end else if (narrow_q) begin
            rd_data = {ext_din[7:0], lo_q};
        end else begin
            rd_data = ext_din;
        end
    end
endmodule

// File: rtl/xmem_waitctl.sv
module xmem_waitctl
    import xmem_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] ROM_LO = 16'h0000,
    parameter logic [AW-1:0] ROM_HI = 16'h3FFF,
    parameter logic [AW-1:0] RAM_LO = 16'h4000,
    parameter logic [AW-1:0] RAM_HI = 16'h7FFF,
    parameter logic [AW-1:0] XM_LO  = 16'h8000,
    parameter logic [AW-1:0] XM_HI  = 16'hBFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic          rdy,
    output logic [15:0]   rd_data,
    output logic [AW:0]   ext_addr,
    output logic [15:0]   ext_dout,
    input  logic [15:0]   ext_din,
    output logic          ext_oe_n,
    output logic          ext_we_n,
    output logic          ram_cs_n,
    output logic          rom_cs_n,
    output logic          xm_cs_n
);
    logic [15:0]       cfg_q;
    region_e           dec_region;
    logic [WAIT_W-1:0] dec_wait;
    logic              dec_narrow;

    xmem_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    xmem_decode #(
        .AW(AW), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .RAM_LO(RAM_LO),
        .RAM_HI(RAM_HI), .XM_LO(XM_LO), .XM_HI(XM_HI)
    ) u_dec (
        .addr       (req_addr),
        .cfg_fields (cfg_q[11:0]),
        .region     (dec_region),
        .wait_cnt   (dec_wait),
        .narrow     (dec_narrow)
    );

    xmem_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_wr     (req_wr),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .dec_region (dec_region),
        .dec_wait   (dec_wait),
        .dec_narrow (dec_narrow),
        .mrg_ram    (cfg_q[RAM_MRG]),
        .mrg_rom    (cfg_q[ROM_MRG]),
        .ext_din    (ext_din),
        .rdy        (rdy),
        .rd_data    (rd_data),
        .ext_addr   (ext_addr),
        .ext_dout   (ext_dout),
        .ext_oe_n   (ext_oe_n),
        .ext_we_n   (ext_we_n),
        .ram_cs_n   (ram_cs_n),
        .rom_cs_n   (rom_cs_n),
        .xm_cs_n    (xm_cs_n)
    );

    assign cfg_rdata = cfg_q;
endmodule

// File: rtl/xmem_chk.sv
module xmem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cfg_rdata,
    input logic        rdy,
    input logic        ext_oe_n,
    input logic        ext_we_n,
    input logic        ram_cs_n,
    input logic        rom_cs_n,
    input logic        xm_cs_n
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15:14] == 2'b00); // R2

    AST_RAM_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[13] && !xm_cs_n) |-> !ram_cs_n); // R8

    AST_ROM_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[12] && !xm_cs_n) |-> !rom_cs_n); // R9

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[13:12] == 2'b00) |-> ($countones({~ram_cs_n, ~rom_cs_n, ~xm_cs_n}) <= 1)); // R10

    AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_oe_n && !rdy) |=> !ext_oe_n); // R10

    AST_WE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_we_n && !rdy) |=> !ext_we_n); // R10

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy); // R4

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n)); // R10
endmodule

bind xmem_waitctl xmem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .rdy       (rdy),
    .ext_oe_n  (ext_oe_n),
    .ext_we_n  (ext_we_n),
    .ram_cs_n  (ram_cs_n),
    .rom_cs_n  (rom_cs_n),
    .xm_cs_n   (xm_cs_n)
);

// File: tb/sim_xmem_waitctl.sv
`timescale 1ns/1ps
module sim_xmem_waitctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rdy;
    logic [15:0] rd_data;
    logic [16:0] ext_addr;
    logic [15:0] ext_dout;
    logic [15:0] ext_din;
    logic        ext_oe_n, ext_we_n, ram_cs_n, rom_cs_n, xm_cs_n;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // external device: data is a function of the byte address
    assign ext_din = ext_addr[15:0] ^ 16'hA5C3;

    xmem_waitctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rdy(rdy), .rd_data(rd_data), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_din(ext_din), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
        .xm_cs_n(xm_cs_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // per-access observations
    int          o_n;
    logic [15:0] o_rd, o_w16;
    logic [7:0]  o_wlo, o_whi;
    logic        o_ram, o_rom, o_xm, o_lsb_first, o_lsb_last, o_strobe_ok;

    task automatic access(input logic [15:0] a, input logic wr, input logic [15:0] wd,
                          input logic mapped);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
        o_n = 0; o_rd = '0; o_w16 = '0; o_wlo = '0; o_whi = '0;
        o_ram = 0; o_rom = 0; o_xm = 0; o_strobe_ok = 1'b1;
        o_lsb_first = 0; o_lsb_last = 0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            o_n++;
            if (!ram_cs_n) o_ram = 1;
            if (!rom_cs_n) o_rom = 1;
            if (!xm_cs_n)  o_xm = 1;
            if (o_n == 1) o_lsb_first = ext_addr[0];
            o_lsb_last = ext_addr[0];
            if (mapped) begin
                if (wr ? (ext_we_n || !ext_oe_n) : (ext_oe_n || !ext_we_n)) o_strobe_ok = 0;
            end else if (!ext_we_n || !ext_oe_n) begin
                o_strobe_ok = 0;
            end
            if (!ext_we_n) begin
                o_w16 = ext_dout;
                if (ext_addr[0]) o_whi = ext_dout[7:0];
                else             o_wlo = ext_dout[7:0];
            end
            if (rdy) begin
                o_rd = rd_data;
                break;
            end
            if (o_n > 40) break;
        end
        @(posedge clk);
        #1 req = 1'b0;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] bases [3];
        bases[0] = 16'h4000; // RAM
        bases[1] = 16'h0000; // ROM
        bases[2] = 16'h8000; // extended
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cfg", cfg_rdata, 16'h0000);
        chk("R1 selects", {ram_cs_n, rom_cs_n, xm_cs_n}, 3'b111);
        chk("R1 strobes", {ext_oe_n, ext_we_n}, 2'b11);
        chk("R1 rdy", rdy, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rdy after release", rdy, 1'b0);

        // R2 reserved bits
        set_cfg(16'hFFFF);
        chk("R2 reserved read 0", cfg_rdata, 16'h3FFF);
        set_cfg(16'h0000);

        // sweep region x width x wait x direction
        for (int r = 0; r < 3; r++) begin
            for (int w8 = 0; w8 < 2; w8++) begin
                for (int wt = 0; wt < 8; wt++) begin
                    logic [15:0] cv, a, wd, e_rd;
                    logic [3:0]  mine, other;
                    int          beats;
                    mine  = {w8[0], wt[2:0]};
                    other = {~w8[0], 3'(7 - wt)};
                    cv = 16'h0;
                    for (int k = 0; k < 3; k++) cv[4*k +: 4] = (k == r) ? mine : other;
                    set_cfg(cv);
                    chk("R2 readback", cfg_rdata, cv);
                    a  = bases[r] + 16'h0120 + 16'(wt * 3 + w8);
                    wd = 16'h3C00 ^ 16'(r * 4096 + wt * 257 + w8 * 17);
                    beats = (w8 != 0) ? 2 * (wt + 1) : (wt + 1);
                    // write
                    access(a, 1'b1, wd, 1'b1);
                    chk("R4/R5 write cycles", o_n, beats);
                    chk("R3 region select", {o_ram, o_rom, o_xm}, 3'(3'b100 >> r));
                    chk("R10 write strobe held", o_strobe_ok, 1'b1);
                    if (w8 != 0) begin
                        chk("R7 low byte lane", o_wlo, wd[7:0]);
                        chk("R7 high byte lane", o_whi, wd[15:8]);
                        chk("R5 byte order", {o_lsb_first, o_lsb_last}, 2'b01);
                    end else begin
                        chk("R7 word write", o_w16, wd);
                        chk("R5 no split", {o_lsb_first, o_lsb_last}, 2'b00);
                    end
                    // read
                    access(a, 1'b0, 16'h0, 1'b1);
                    chk("R4/R5 read cycles", o_n, beats);
                    chk("R10 read strobe held", o_strobe_ok, 1'b1);
                    if (w8 != 0) begin
                        e_rd = {8'({a, 1'b1} ^ 17'h0A5C3), 8'({a, 1'b0} ^ 17'h0A5C3)};
                    end else begin
                        e_rd = 16'({a, 1'b0}) ^ 16'hA5C3;
                    end
                    chk("R6 read data", o_rd, e_rd);
                end
            end
        end

        // R3 window edges, all fields zero
        set_cfg(16'h0000);
        access(16'h3FFF, 1'b0, 16'h0, 1'b1);
        chk("R3 0x3FFF is ROM", {o_ram, o_rom, o_xm}, 3'b010);
        access(16'h4000, 1'b0, 16'h0, 1'b1);
        chk("R3 0x4000 is RAM", {o_ram, o_rom, o_xm}, 3'b100);
        access(16'h7FFF, 1'b0, 16'h0, 1'b1);
        chk("R3 0x7FFF is RAM", {o_ram, o_rom, o_xm}, 3'b100);
        access(16'h8000, 1'b0, 16'h0, 1'b1);
        chk("R3 0x8000 is ext", {o_ram, o_rom, o_xm}, 3'b001);
        access(16'hBFFF, 1'b0, 16'h0, 1'b1);
        chk("R3 0xBFFF is ext", {o_ram, o_rom, o_xm}, 3'b001);
        set_cfg(16'h0FFF);
        access(16'hC000, 1'b0, 16'h0, 1'b0);
        chk("R3 unmapped select", {o_ram, o_rom, o_xm}, 3'b000);
        chk("R3 unmapped strobes", o_strobe_ok, 1'b1);
        chk("R3 unmapped cycles", o_n, 1);
        chk("R3 unmapped data", o_rd, 16'h0000);
        access(16'hFFFF, 1'b1, 16'h1234, 1'b0);
        chk("R3 unmapped write", {o_ram, o_rom, o_xm, o_strobe_ok}, 4'b0001);

        // R8 / R9 merge combinations
        for (int m = 0; m < 4; m++) begin
            set_cfg(16'(m) << 12);
            access(16'h9000, 1'b0, 16'h0, 1'b1);
            chk("R8 ram follows ext", o_ram, m[1]);
            chk("R9 rom follows ext", o_rom, m[0]);
            chk("R10 ext select", o_xm, 1'b1);
        end
        set_cfg(16'h3000);
        access(16'h5000, 1'b0, 16'h0, 1'b1);
        chk("R10 merge idle on RAM access", {o_ram, o_rom, o_xm}, 3'b100);
        access(16'h1000, 1'b1, 16'h55AA, 1'b1);
        chk("R10 merge idle on ROM access", {o_ram, o_rom, o_xm}, 3'b010);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule